// File: doc/BRIEF.md
# Hardware Semaphore Bank

This block gives up to eight processor masters exclusive, race-free ownership of shared resources. It holds a bank of independent semaphores. Each one has a lock bit, an owner ID and a first-in first-out list of waiting masters. None of the semaphores is tied to a particular hardware resource. Software decides what each one guards. Every access carries a privilege ID. IDs 0 to 7 are the masters. Any other ID is refused: a read returns zero, and no state changes.

Masters reach the block through one or more register ports. Each port has read and write strobes, a byte address into a 2 KB window, write data and a privilege ID. Read data comes back on the next cycle with a valid pulse. The ports have no back-pressure: every strobe is accepted in the cycle it is presented.

The window has three regions:

- **Direct acquire/release.** Reading a semaphore's direct word is an indivisible test-and-set. Writing that word releases the semaphore.
- **Queued request and status.** Writing a semaphore's queued word asks for ownership. A master that finds the semaphore busy waits in line instead of spinning. Reading the word shows the semaphore's state.
- **Per-master flags.** When a semaphore is handed to a master through the queue, a flag bit is set for that master. Each master's interrupt line is high while any of its flags is set.

All accesses that arrive in the same cycle are applied one after another, lowest privilege ID first.

Top module: `hsem_bank`

## Requirements
- R1: When a semaphore is free, a read of its direct word (byte address 0x000 + 4*s, s in 0..31) returns 1 and locks the semaphore to the reader.
- R2: When a semaphore is held, a read of its direct word returns 0 and changes no state.
- R3: A write with bit 0 set to a direct word releases the semaphore only if the writer is its owner. A write from any other master changes nothing.
- R4: An access whose privilege ID is 8 or more has no effect on any semaphore or flag, and its read returns 0.
- R5: A write with bit 0 set to a queued word (0x100 + 4*s) while the semaphore is held by another master appends the writer to that semaphore's wait list. A master already waiting is not added twice. When the owner releases, ownership passes to the oldest waiter, and that waiter's flag bit s is set.
- R6: A queued-word write to a free semaphore grants it to the writer at once and sets the writer's flag bit s.
- R7: The flag word of master m (0x200 + 4*m) reads back a mask of flag bits, bit s for semaphore s. Writing ones clears the matching bits, but only when the writer's privilege ID equals m.
- R8: irq[m] is high exactly while master m has any flag bit set. It rises at the clock edge that records the grant.
- R9: All accesses in one cycle are applied in order of ascending privilege ID, and each one sees the effect of those before it. For one ID on several ports, the lower port index goes first. Of two acquires of one free semaphore, only the lower ID gets 1.
- R10: A read of a queued word returns the semaphore's state at the start of that cycle: bit 0 is the lock bit, bits 6:4 are the owner ID, and bits 11:8 are the number of waiters.
- R11: Every read strobe gets rvalid and its data in the following cycle, with nothing in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_rd | input | N_PORT | Read strobe per port |
| p_wr | input | N_PORT | Write strobe per port |
| p_addr | input | N_PORT x AW | Byte address per port |
| p_wdata | input | N_PORT x DW | Write data per port |
| p_pid | input | N_PORT x PIDW | Privilege ID of the access per port |
| p_rvalid | output | N_PORT | Read data valid, one cycle after the strobe |
| p_rdata | output | N_PORT x DW | Read data per port |
| irq | output | N_MST | Grant interrupt per master |

## Verification
The bench uses the default sizes: 32 semaphores, 8 masters, 4-bit privilege IDs and two ports. Two ports make same-cycle collisions possible. With them the bench can check the ascending-ID order, including a release and an acquire of one semaphore in the same cycle. The 4-bit ID field leaves room for IDs 8 to 15, so refused accesses can be driven. Eight masters are enough to build a wait list of several masters, with a duplicate request among them.

// File: rtl/hsem_pkg.sv
package hsem_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_ACQ, OP_REL, OP_QREQ} sem_op_e;
  typedef enum logic [1:0] {RD_NONE, RD_ACQ, RD_STAT, RD_FLAG} rd_kind_e;
  localparam int unsigned ST_OWNER_LSB = 4;
  localparam int unsigned ST_CNT_LSB   = 8;
  localparam int unsigned REG_DIRECT   = 0;
  localparam int unsigned REG_QUEUE    = 1;
  localparam int unsigned REG_FLAG     = 2;
endpackage

// File: rtl/hsem_decode.sv
module hsem_decode
  import hsem_pkg::*;
#(
  parameter int unsigned N_SEM = 32,
  parameter int unsigned N_MST = 8,
  parameter int unsigned AW    = 11,
  parameter int unsigned PIDW  = 4,
  parameter int unsigned SEMW  = 5,
  parameter int unsigned MW    = 3
) (
  input  logic            rd,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic            wbit,
  input  logic [PIDW-1:0] pid,
  output sem_op_e         op,
  output rd_kind_e        rkind,
  output logic            flag_clr,
  output logic [SEMW-1:0] sem_idx,
  output logic [MW-1:0]   mst_idx,
  output logic [MW-1:0]   id
);
  localparam int unsigned REGW = AW - 8;

  logic [5:0]      word;
  logic [REGW-1:0] region;
  logic            pid_ok, sem_ok, mst_ok;
  logic            unused_lsb;

  assign unused_lsb = ^addr[1:0];
  assign word     = addr[7:2];
  assign region   = addr[AW-1:8];
  assign sem_idx  = word[SEMW-1:0];
  assign mst_idx  = word[MW-1:0];
  assign id       = pid[MW-1:0];
  assign pid_ok   = {1'b0, pid} < (PIDW+1)'(N_MST);
  assign sem_ok   = {1'b0, word} < 7'(N_SEM);
  assign mst_ok   = {1'b0, word} < 7'(N_MST);

  always_comb begin
    op       = OP_NONE;
    rkind    = RD_NONE;
    flag_clr = 1'b0;
    if (pid_ok) begin
      if (rd) begin
        if (region == REGW'(REG_DIRECT) && sem_ok) begin
          op    = OP_ACQ;
          rkind = RD_ACQ;
        end else if (region == REGW'(REG_QUEUE) && sem_ok) begin
          rkind = RD_STAT;
        end else if (region == REGW'(REG_FLAG) && mst_ok) begin
          rkind = RD_FLAG;
        end
      end else if (wr) begin
        if (region == REGW'(REG_DIRECT) && sem_ok && wbit) begin
          op = OP_REL;
        end else if (region == REGW'(REG_QUEUE) && sem_ok && wbit) begin
          op = OP_QREQ;
        end else if (region == REGW'(REG_FLAG) && mst_ok && mst_idx == id) begin
          flag_clr = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hsem_cell.sv
module hsem_cell
  import hsem_pkg::*;
#(
  parameter int unsigned N_MST  = 8,
  parameter int unsigned N_PORT = 2,
  parameter int unsigned MW     = 3,
  parameter int unsigned CW     = 4,
  parameter int unsigned PW     = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PORT-1:0] hit,
  input  sem_op_e           op   [N_PORT],
  input  logic [MW-1:0]     id   [N_PORT],
  input  logic [PW-1:0]     rank [N_PORT],
  output logic [N_PORT-1:0] acq_ok,
  output logic [N_MST-1:0]  gnt,
  output logic              locked,
  output logic [MW-1:0]     owner,
  output logic [CW-1:0]     cnt
);
  logic [MW-1:0]    q_q [N_MST];
  logic [MW-1:0]    q_n [N_MST];
  logic [N_MST-1:0] wait_q, wait_n;
  logic             lock_n;
  logic [MW-1:0]    own_n;
  logic [CW-1:0]    cnt_n;

  always_comb begin
    lock_n = locked;
    own_n  = owner;
    cnt_n  = cnt;
    wait_n = wait_q;
    q_n    = q_q;
    acq_ok = '0;
    gnt    = '0;
    for (int r = 0; r < N_PORT; r++) begin
      for (int p = 0; p < N_PORT; p++) begin
        if (hit[p] && rank[p] == PW'(r)) begin
          unique case (op[p])
            OP_ACQ: begin
              if (!lock_n) begin
                lock_n    = 1'b1;
                own_n     = id[p];
                acq_ok[p] = 1'b1;
              end
            end
            OP_REL: begin
              if (lock_n && own_n == id[p]) begin
                if (cnt_n != '0) begin
                  own_n          = q_n[0];
                  gnt[q_n[0]]    = 1'b1;
                  wait_n[q_n[0]] = 1'b0;
                  for (int i = 0; i < N_MST - 1; i++) q_n[i] = q_n[i+1];
                  q_n[N_MST-1] = '0;
                  cnt_n        = cnt_n - CW'(1);
                end else begin
                  lock_n = 1'b0;
                end
              end
            end
            OP_QREQ: begin
              if (!lock_n) begin
                lock_n     = 1'b1;
                own_n      = id[p];
                gnt[id[p]] = 1'b1;
              end else if (own_n != id[p] && !wait_n[id[p]]) begin
                q_n[cnt_n[MW-1:0]] = id[p];
                wait_n[id[p]]      = 1'b1;
                cnt_n              = cnt_n + CW'(1);
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      owner  <= '0;
      cnt    <= '0;
      wait_q <= '0;
      for (int i = 0; i < N_MST; i++) q_q[i] <= '0;
    end else begin
      locked <= lock_n;
      owner  <= own_n;
      cnt    <= cnt_n;
      wait_q <= wait_n;
      q_q    <= q_n;
    end
  end
endmodule

// File: rtl/hsem_flags.sv
module hsem_flags #(
  parameter int unsigned N_SEM = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SEM-1:0] set,
  input  logic [N_SEM-1:0] clr,
  output logic [N_SEM-1:0] flags,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set;
  end

  assign irq = |flags;
endmodule

// File: rtl/hsem_bank.sv
module hsem_bank
  import hsem_pkg::*;
#(
  parameter int unsigned N_SEM  = 32,
  parameter int unsigned N_MST  = 8,
  parameter int unsigned N_PORT = 2,
  parameter int unsigned AW     = 11,
  parameter int unsigned DW     = 32,
  parameter int unsigned PIDW   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_PORT-1:0]              p_rd,
  input  logic [N_PORT-1:0]              p_wr,
  input  logic [N_PORT-1:0][AW-1:0]      p_addr,
  input  logic [N_PORT-1:0][DW-1:0]      p_wdata,
  input  logic [N_PORT-1:0][PIDW-1:0]    p_pid,
  output logic [N_PORT-1:0]              p_rvalid,
  output logic [N_PORT-1:0][DW-1:0]      p_rdata,
  output logic [N_MST-1:0]               irq
);
  localparam int unsigned SEMW = $clog2(N_SEM);
  localparam int unsigned MW   = $clog2(N_MST);
  localparam int unsigned CW   = $clog2(N_MST + 1);
  localparam int unsigned PW   = (N_PORT > 1) ? $clog2(N_PORT) : 1;

  sem_op_e         op       [N_PORT];
  rd_kind_e        rkind    [N_PORT];
  logic            flag_clr [N_PORT];
  logic [SEMW-1:0] sem_idx  [N_PORT];
  logic [MW-1:0]   mst_idx  [N_PORT];
  logic [MW-1:0]   id       [N_PORT];
  logic [PW-1:0]   rank     [N_PORT];
  logic [DW-1:0]   rd_word  [N_PORT];

  logic [N_SEM-1:0]          sem_locked;
  logic [N_SEM-1:0][MW-1:0]  sem_owner;
  logic [N_SEM-1:0][CW-1:0]  sem_cnt;
  logic [N_PORT-1:0]         acq_ok [N_SEM];
  logic [N_MST-1:0]          gnt    [N_SEM];
  logic [N_SEM-1:0]          flags  [N_MST];
  logic [N_SEM-1:0]          fset   [N_MST];
  logic [N_SEM-1:0]          fclr   [N_MST];

  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    hsem_decode #(
      .N_SEM(N_SEM), .N_MST(N_MST), .AW(AW), .PIDW(PIDW), .SEMW(SEMW), .MW(MW)
    ) u_dec (
      .rd(p_rd[p]), .wr(p_wr[p]), .addr(p_addr[p]), .wbit(p_wdata[p][0]),
      .pid(p_pid[p]), .op(op[p]), .rkind(rkind[p]), .flag_clr(flag_clr[p]),
      .sem_idx(sem_idx[p]), .mst_idx(mst_idx[p]), .id(id[p])
    );
  end

  // Order of application: ascending privilege ID, then ascending port index.
  always_comb begin
    for (int p = 0; p < N_PORT; p++) begin
      rank[p] = '0;
      for (int q = 0; q < N_PORT; q++) begin
        if (q != p && (p_pid[q] < p_pid[p] || (p_pid[q] == p_pid[p] && q < p)))
          rank[p] = rank[p] + PW'(1);
      end
    end
  end

  for (genvar s = 0; s < N_SEM; s++) begin : g_sem
    logic [N_PORT-1:0] hit;
    always_comb begin
      for (int p = 0; p < N_PORT; p++)
        hit[p] = (op[p] != OP_NONE) && (sem_idx[p] == SEMW'(s));
    end
    hsem_cell #(
      .N_MST(N_MST), .N_PORT(N_PORT), .MW(MW), .CW(CW), .PW(PW)
    ) u_cell (
      .clk(clk), .rst_n(rst_n), .hit(hit), .op(op), .id(id), .rank(rank),
      .acq_ok(acq_ok[s]), .gnt(gnt[s]), .locked(sem_locked[s]),
      .owner(sem_owner[s]), .cnt(sem_cnt[s])
    );
  end

  always_comb begin
    for (int m = 0; m < N_MST; m++) begin
      fset[m] = '0;
      fclr[m] = '0;
      for (int s = 0; s < N_SEM; s++) fset[m][s] = gnt[s][m];
      for (int p = 0; p < N_PORT; p++)
        if (flag_clr[p] && mst_idx[p] == MW'(m)) fclr[m] = fclr[m] | p_wdata[p][N_SEM-1:0];
    end
  end

  for (genvar m = 0; m < N_MST; m++) begin : g_mst
    hsem_flags #(.N_SEM(N_SEM)) u_flg (
      .clk(clk), .rst_n(rst_n), .set(fset[m]), .clr(fclr[m]),
      .flags(flags[m]), .irq(irq[m])
    );
  end

  always_comb begin
    for (int p = 0; p < N_PORT; p++) begin
      rd_word[p] = '0;
      unique case (rkind[p])
        RD_ACQ:  rd_word[p] = DW'(acq_ok[sem_idx[p]][p]);
        RD_STAT: begin
          rd_word[p][0]                  = sem_locked[sem_idx[p]];
          rd_word[p][ST_OWNER_LSB +: MW] = sem_owner[sem_idx[p]];
          rd_word[p][ST_CNT_LSB +: CW]   = sem_cnt[sem_idx[p]];
        end
        RD_FLAG: rd_word[p] = DW'(flags[mst_idx[p]]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_rvalid <= '0;
      p_rdata  <= '0;
    end else begin
      p_rvalid <= p_rd;
      for (int p = 0; p < N_PORT; p++) p_rdata[p] <= rd_word[p];
    end
  end
endmodule

// File: rtl/hsem_bank_chk.sv
module hsem_bank_chk #(
  parameter int unsigned N_SEM  = 32,
  parameter int unsigned N_MST  = 8,
  parameter int unsigned N_PORT = 2,
  parameter int unsigned AW     = 11,
  parameter int unsigned DW     = 32,
  parameter int unsigned PIDW   = 4,
  parameter int unsigned MW     = 3,
  parameter int unsigned CW     = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [N_PORT-1:0]           p_rd,
  input logic [N_PORT-1:0]           p_wr,
  input logic [N_PORT-1:0][AW-1:0]   p_addr,
  input logic [N_PORT-1:0][PIDW-1:0] p_pid,
  input logic [N_PORT-1:0]           p_rvalid,
  input logic [N_PORT-1:0][DW-1:0]   p_rdata,
  input logic [N_MST-1:0]            irq,
  input logic [N_SEM-1:0]            sem_locked,
  input logic [N_SEM-1:0][MW-1:0]    sem_owner,
  input logic [N_SEM-1:0][CW-1:0]    sem_cnt
);
  logic              any_ok;
  logic [N_PORT-1:0] flag_rd, irq_of;

  always_comb begin
    any_ok = 1'b0;
    for (int p = 0; p < N_PORT; p++) begin
      if ((p_rd[p] || p_wr[p]) && ({1'b0, p_pid[p]} < (PIDW+1)'(N_MST))) any_ok = 1'b1;
      flag_rd[p] = p_rd[p] && ({1'b0, p_pid[p]} < (PIDW+1)'(N_MST))
                   && p_addr[p][AW-1:8] == (AW-8)'(2)
                   && ({1'b0, p_addr[p][7:2]} < 7'(N_MST));
      irq_of[p] = irq[p_addr[p][2 +: MW]];
    end
  end

  assert_rejected_no_effect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !any_ok |=> ($stable(sem_locked) && $stable(sem_owner) && $stable(sem_cnt)));

  for (genvar s = 0; s < N_SEM; s++) begin : g_s
    assert_free_has_no_waiters_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !sem_locked[s] |-> (sem_cnt[s] == '0));
  end

  for (genvar p = 0; p < N_PORT; p++) begin : g_p
    assert_rvalid_follows_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
      p_rd[p] |=> p_rvalid[p]);
    assert_flag_word_matches_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (p_rvalid[p] && $past(flag_rd[p])) |-> ((p_rdata[p] != '0) == $past(irq_of[p])));
    for (genvar q = p + 1; q < N_PORT; q++) begin : g_q
      assert_single_winner_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (p_rvalid[p] && p_rvalid[q] && $past(p_addr[p] == p_addr[q])
         && $past(p_addr[p][AW-1:8] == '0))
        |-> !(p_rdata[p][0] && p_rdata[q][0]));
    end
  end
endmodule

bind hsem_bank hsem_bank_chk #(
  .N_SEM(N_SEM), .N_MST(N_MST), .N_PORT(N_PORT), .AW(AW), .DW(DW), .PIDW(PIDW),
  .MW(MW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .p_rd(p_rd), .p_wr(p_wr), .p_addr(p_addr), .p_pid(p_pid),
  .p_rvalid(p_rvalid), .p_rdata(p_rdata), .irq(irq), .sem_locked(sem_locked),
  .sem_owner(sem_owner), .sem_cnt(sem_cnt)
);

// File: tb/hsem_bank_bench.sv
`timescale 1ns/1ps
module hsem_bank_bench;
  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      p_rd = '0;
  logic [1:0]      p_wr = '0;
  logic [1:0][10:0] p_addr = '0;
  logic [1:0][31:0] p_wdata = '0;
  logic [1:0][3:0]  p_pid = '0;
  logic [1:0]       p_rvalid;
  logic [1:0][31:0] p_rdata;
  logic [7:0]       irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hsem_bank u_hsem_bank (
    .clk(clk), .rst_n(rst_n), .p_rd(p_rd), .p_wr(p_wr), .p_addr(p_addr),
    .p_wdata(p_wdata), .p_pid(p_pid), .p_rvalid(p_rvalid), .p_rdata(p_rdata), .irq(irq)
  );

  // Row: [19] check, [18] rd, [17] wr, [16] wdata bit0, [15:12] pid, [11:1] addr, [0] expected bit
  localparam logic [19:0] VEC [12] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd2,  11'h014, 1'b1},  // R1 pid2 takes sem5
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd3,  11'h014, 1'b0},  // R2 held
    {1'b0, 1'b0, 1'b1, 1'b1, 4'd3,  11'h014, 1'b0},  // R3 foreign release
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd3,  11'h014, 1'b0},  // R3 still held
    {1'b0, 1'b0, 1'b1, 1'b1, 4'd2,  11'h014, 1'b0},  // R3 owner release
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd3,  11'h014, 1'b1},  // R3 now free
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd9,  11'h01C, 1'b0},  // R4 refused ID
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd1,  11'h01C, 1'b1},  // R4 sem7 untouched
    {1'b0, 1'b0, 1'b1, 1'b1, 4'd12, 11'h01C, 1'b0},  // R4 refused release
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd4,  11'h01C, 1'b0},  // R4 still held
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd1,  11'h07C, 1'b1},  // R1 last semaphore
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd0,  11'h07C, 1'b0}   // R2 held
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input int p, input bit rd, input bit wr, input logic [10:0] a,
                     input logic [31:0] wd, input logic [3:0] pid);
    p_rd[p] = rd; p_wr[p] = wr; p_addr[p] = a; p_wdata[p] = wd; p_pid[p] = pid;
  endtask

  task automatic tick();
    @(negedge clk);
    p_rd = '0;
    p_wr = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 rvalid in reset", 32'(p_rvalid), 32'h0);
    chk("R8 irq in reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    put(0, 1, 0, 11'h100, 0, 4'd0); tick();
    chk("R10 status of sem0 after reset", p_rdata[0], 32'h0);
    chk("R11 rvalid after read", 32'(p_rvalid[0]), 32'h1);

    for (int i = 0; i < 12; i++) begin
      put(0, VEC[i][18], VEC[i][17], VEC[i][11:1], {31'b0, VEC[i][16]}, VEC[i][15:12]);
      tick();
      if (VEC[i][19]) chk($sformatf("R1 R2 R3 R4 table row %0d", i), p_rdata[0], {31'b0, VEC[i][0]});
    end

    // R5 queue on sem10
    put(0, 1, 0, 11'h028, 0, 4'd1); tick();
    chk("R1 pid1 takes sem10", p_rdata[0], 32'h1);
    put(0, 0, 1, 11'h128, 1, 4'd4); tick();
    put(0, 0, 1, 11'h128, 1, 4'd6); tick();
    put(0, 0, 1, 11'h128, 1, 4'd4); tick();
    put(0, 1, 0, 11'h128, 0, 4'd1); tick();
    chk("R10 R5 status two waiters", p_rdata[0], 32'h211);
    chk("R5 no irq while waiting", 32'(irq), 32'h0);
    put(0, 0, 1, 11'h028, 1, 4'd1); tick();
    chk("R5 oldest waiter flagged", 32'(irq), 32'h10);
    put(0, 1, 0, 11'h128, 0, 4'd0); tick();
    chk("R5 owner now pid4", p_rdata[0], 32'h141);
    put(0, 1, 0, 11'h210, 0, 4'd0); tick();
    chk("R7 flag word of master4", p_rdata[0], 32'h400);
    put(0, 0, 1, 11'h028, 1, 4'd4); tick();
    chk("R5 second waiter flagged", 32'(irq), 32'h50);
    put(0, 1, 0, 11'h128, 0, 4'd0); tick();
    chk("R5 owner pid6 queue empty", p_rdata[0], 32'h61);
    put(0, 0, 1, 11'h210, 32'h400, 4'd3); tick();
    chk("R7 foreign clear ignored", 32'(irq), 32'h50);
    put(0, 0, 1, 11'h210, 32'h400, 4'd4); tick();
    chk("R7 R8 own clear drops irq4", 32'(irq), 32'h40);
    put(0, 0, 1, 11'h218, 32'h400, 4'd6); tick();
    chk("R7 R8 own clear drops irq6", 32'(irq), 32'h0);

    // R6 queued request on free sem20
    put(0, 0, 1, 11'h150, 1, 4'd5); tick();
    chk("R6 immediate grant irq", 32'(irq), 32'h20);
    put(0, 1, 0, 11'h150, 0, 4'd5); tick();
    chk("R6 owner pid5", p_rdata[0], 32'h51);

    // R9 same-cycle ordering on sem3
    put(0, 1, 0, 11'h00C, 0, 4'd6); put(1, 1, 0, 11'h00C, 0, 4'd2); tick();
    chk("R9 higher ID loses", p_rdata[0], 32'h0);
    chk("R9 lower ID wins", p_rdata[1], 32'h1);
    put(0, 1, 0, 11'h00C, 0, 4'd6); put(1, 0, 1, 11'h00C, 1, 4'd2); tick();
    chk("R9 release applied before later acquire", p_rdata[0], 32'h1);
    put(0, 1, 0, 11'h010, 0, 4'd1); put(1, 1, 0, 11'h010, 0, 4'd5); tick();
    chk("R9 port0 lower ID wins", p_rdata[0], 32'h1);
    chk("R9 port1 loses", p_rdata[1], 32'h0);
    put(1, 1, 0, 11'h10C, 0, 4'd15); tick();
    chk("R4 refused status read", p_rdata[1], 32'h0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule